// File: doc/BRIEF.md
# Scan-Locked Programmable Signal Generator

This block produces one programmable control waveform for a display panel timing engine. The waveform stays in step with the panel scan. A local counter is armed by a start event. The event is built from the current frame phase and line phase, and a match on a chosen global counter can narrow it further. Once running, the counter advances on a selectable tick source. A registered output level goes high and low when the counter reaches two programmed compare values.

The registered level can be combined with one neighbouring generated signal, chosen by index. The result can be inverted, and it is held at its idle level while the generator is off. Several instances side by side can feed one another through the neighbour-signal bus. This allows chained or gated waveforms, such as a pulse that only ticks on another signal's activity.

Top module: `scan_sig_gen`

## Requirements
- R1: The start mask is 8 bits. Bits 0..3 enable the frame phases sync, begin, data and end (the `frame_phase` one-hot bits 0..3). Bits 4..7 enable the line phases sync, begin, data and end (the `line_phase` one-hot bits 0..3). The start condition needs the current frame phase and the current line phase to both be enabled. A start event fires on the first clock where the start condition becomes true.
- R2: When `cfg_gsel` is below 8, the start condition also requires global counter `cfg_gsel` to equal `cfg_start_cnt`. Counter g sits at bits [12g+11:12g] of `gcnt_bus`. When `cfg_gsel` is 8 or above, no global match is needed.
- R3: A start event loads the local counter with 0 at that clock edge. Afterwards the counter adds one on each clock where the selected tick is high.
- R4: `cfg_tick_sel` picks the tick source: 0 is `pix_en`, 1 is `line_start`, 2 is `frame_start`, and 3 is the selected neighbour signal.
- R5: Each time the counter takes a new value, the raw level is updated. It is set to 1 if the value equals `cfg_set_cnt`, otherwise it is cleared to 0 if the value equals `cfg_clr_cnt`. Set wins when the two counts are equal.
- R6: The counter stops at 65535 and does not wrap. A new start event returns it to 0.
- R7: The output is picked by `cfg_comb`. 0 passes the neighbour signal through. 1 gives raw AND neighbour. 2 gives raw OR neighbour. 3 gives a one-cycle start strobe AND neighbour; the strobe is high in the cycle after a start event.
- R8: When `cfg_pol` is 1, the combined output is inverted.
- R9: When `cfg_en` is 0, `sig_out` equals `cfg_pol`. The counter and the raw level are also cleared.
- R10: `cfg_nbr_idx` selects which bit of `nbr_sigs` is used as the neighbour signal, both for the tick and for combining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable |
| line_start | input | 1 | Line start pulse |
| frame_start | input | 1 | Frame start pulse |
| frame_phase | input | 4 | One-hot frame phase: sync, begin, data, end |
| line_phase | input | 4 | One-hot line phase: sync, begin, data, end |
| gcnt_bus | input | 96 | Eight packed 12-bit global counters |
| nbr_sigs | input | 32 | Neighbouring generated signals |
| cfg_en | input | 1 | Generator enable |
| cfg_pol | input | 1 | Output inversion |
| cfg_tick_sel | input | 2 | Tick source select |
| cfg_gsel | input | 4 | Global counter select for start refinement |
| cfg_start_cnt | input | 12 | Global counter match value |
| cfg_start_mask | input | 8 | Frame and line phase start mask |
| cfg_set_cnt | input | 16 | Counter value that sets the raw level |
| cfg_clr_cnt | input | 16 | Counter value that clears the raw level |
| cfg_comb | input | 2 | Output combine code |
| cfg_nbr_idx | input | 5 | Neighbour signal index |
| sig_out | output | 1 | Generated signal |

## Verification
A run that stays in the data/data phase shows the set-to-clear window with the pixel tick. A run whose line phase is not enabled shows that the mask truly gates the start. The global-counter test gives the match value to an unselected counter before the selected one, which separates a correct select from an any-counter match. Sparse line, frame and neighbour pulses against a free-running pixel enable show that only the chosen source advances the counter. The compare pattern with clear at zero and set at the top value shows the difference between saturation and wrap, and shows that a restart clears the counter.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    TICK_PIX   = 2'd0,
    TICK_LINE  = 2'd1,
    TICK_FRAME = 2'd2,
    TICK_NBR   = 2'd3
  } tick_sel_e;

  typedef enum logic [1:0] {
    CMB_PASS  = 2'd0,
    CMB_AND   = 2'd1,
    CMB_OR    = 2'd2,
    CMB_STRT  = 2'd3
  } comb_e;
endpackage

// File: rtl/sg_start_qual.sv
module sg_start_qual #(
  parameter int GC_N   = 8,
  parameter int GC_W   = 12,
  parameter int GSEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [3:0]           frame_phase,
  input  logic [3:0]           line_phase,
  input  logic [7:0]           mask,
  input  logic [GC_N*GC_W-1:0] gcnt_bus,
  input  logic [GSEL_W-1:0]    gsel,
  input  logic [GC_W-1:0]      start_cnt,
  output logic                 start
);
  localparam int GI_W = (GC_N > 1) ? $clog2(GC_N) : 1;

  logic [GC_N-1:0] hit;
  logic            gmatch;
  logic            qual;
  logic            qual_q;

  for (genvar g = 0; g < GC_N; g++) begin : g_hit
    assign hit[g] = (gcnt_bus[g*GC_W +: GC_W] == start_cnt);
  end

  always_comb begin
    gmatch = 1'b1;
    if (32'(gsel) < GC_N) gmatch = hit[gsel[GI_W-1:0]];
  end

  assign qual  = en & (|(mask[3:0] & frame_phase)) & (|(mask[7:4] & line_phase)) & gmatch;
  assign start = qual & ~qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end
endmodule

// File: rtl/sg_local_cnt.sv
module sg_local_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] set_val,
  input  logic [CNT_W-1:0] clr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             raw,
  output logic             strt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_n, nv;
  logic             run_n, raw_n, strt_n, load;

  always_comb begin
    cnt_n  = cnt;
    run_n  = running;
    raw_n  = raw;
    strt_n = 1'b0;
    load   = 1'b0;
    nv     = cnt;
    if (!en) begin
      cnt_n = '0;
      run_n = 1'b0;
      raw_n = 1'b0;
    end else if (start) begin
      nv     = '0;
      load   = 1'b1;
      run_n  = 1'b1;
      strt_n = 1'b1;
    end else if (running && tick && (cnt != CNT_MAX)) begin
      nv   = cnt + 1'b1;
      load = 1'b1;
    end
    if (load) begin
      cnt_n = nv;
      if (nv == set_val)      raw_n = 1'b1;
      else if (nv == clr_val) raw_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      raw     <= 1'b0;
      strt_q  <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      running <= run_n;
      raw     <= raw_n;
      strt_q  <= strt_n;
    end
  end
endmodule

// File: rtl/sg_out_mux.sv
module sg_out_mux
  import sg_pkg::*;
(
  input  logic       en,
  input  logic       pol,
  input  logic [1:0] comb,
  input  logic       raw,
  input  logic       strt,
  input  logic       nbr,
  output logic       out
);
  logic mixed;

  always_comb begin
    unique case (comb_e'(comb))
      CMB_PASS: mixed = nbr;
      CMB_AND:  mixed = raw & nbr;
      CMB_OR:   mixed = raw | nbr;
      default:  mixed = strt & nbr;
    endcase
    out = en ? (mixed ^ pol) : pol;
  end
endmodule

// File: rtl/scan_sig_gen.sv
module scan_sig_gen
  import sg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GC_N   = 8,
  parameter int GC_W   = 12,
  parameter int GSEL_W = 4,
  parameter int NBR_N  = 32,
  localparam int NI_W  = (NBR_N > 1) ? $clog2(NBR_N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic                 line_start,
  input  logic                 frame_start,
  input  logic [3:0]           frame_phase,
  input  logic [3:0]           line_phase,
  input  logic [GC_N*GC_W-1:0] gcnt_bus,
  input  logic [NBR_N-1:0]     nbr_sigs,
  input  logic                 cfg_en,
  input  logic                 cfg_pol,
  input  logic [1:0]           cfg_tick_sel,
  input  logic [GSEL_W-1:0]    cfg_gsel,
  input  logic [GC_W-1:0]      cfg_start_cnt,
  input  logic [7:0]           cfg_start_mask,
  input  logic [CNT_W-1:0]     cfg_set_cnt,
  input  logic [CNT_W-1:0]     cfg_clr_cnt,
  input  logic [1:0]           cfg_comb,
  input  logic [NI_W-1:0]      cfg_nbr_idx,
  output logic                 sig_out
);
  logic             start, tick, nbr;
  logic             running, raw, strt_q;
  logic [CNT_W-1:0] cnt;

  assign nbr = nbr_sigs[cfg_nbr_idx];

  always_comb begin
    unique case (tick_sel_e'(cfg_tick_sel))
      TICK_PIX:   tick = pix_en;
      TICK_LINE:  tick = line_start;
      TICK_FRAME: tick = frame_start;
      default:    tick = nbr;
    endcase
  end

  sg_start_qual #(.GC_N(GC_N), .GC_W(GC_W), .GSEL_W(GSEL_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .frame_phase(frame_phase), .line_phase(line_phase),
    .mask(cfg_start_mask), .gcnt_bus(gcnt_bus),
    .gsel(cfg_gsel), .start_cnt(cfg_start_cnt), .start(start)
  );

  sg_local_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .start(start), .tick(tick),
    .set_val(cfg_set_cnt), .clr_val(cfg_clr_cnt),
    .cnt(cnt), .running(running), .raw(raw), .strt_q(strt_q)
  );

  sg_out_mux u_mux (
    .en(cfg_en), .pol(cfg_pol), .comb(cfg_comb),
    .raw(raw), .strt(strt_q), .nbr(nbr), .out(sig_out)
  );
endmodule

// File: rtl/scan_sig_gen_chk.sv
module scan_sig_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_pol,
  input logic [CNT_W-1:0] cfg_set_cnt,
  input logic             start,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             raw,
  input logic             strt_q,
  input logic             sig_out
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && start) |=> (cnt == '0)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && running && !start && tick && cnt != CMAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !start && cnt == CMAX) |=> (cnt == CMAX)); // R6

  AST_SET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && start && cfg_set_cnt == '0) |=> raw); // R5

  AST_STRT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strt_q |=> !strt_q); // R7

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (sig_out == cfg_pol)); // R9
endmodule

bind scan_sig_gen scan_sig_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
  .cfg_set_cnt(cfg_set_cnt), .start(start), .tick(tick), .cnt(cnt),
  .running(running), .raw(raw), .strt_q(strt_q), .sig_out(sig_out)
);

// File: tb/tb_scan_sig_gen.sv
module tb_scan_sig_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en, line_start, frame_start;
  logic [3:0]  frame_phase, line_phase;
  logic [95:0] gcnt_bus;
  logic [31:0] nbr_sigs;
  logic        cfg_en, cfg_pol;
  logic [1:0]  cfg_tick_sel, cfg_comb;
  logic [3:0]  cfg_gsel;
  logic [11:0] cfg_start_cnt;
  logic [7:0]  cfg_start_mask;
  logic [15:0] cfg_set_cnt, cfg_clr_cnt;
  logic [4:0]  cfg_nbr_idx;
  logic        sig_out;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  scan_sig_gen dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sig_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // generator off, phases idle, then back on with the given setup
  task automatic rearm(input logic [1:0] tsel, input logic [15:0] s, input logic [15:0] c);
    cfg_en = 1'b0; frame_phase = 4'b0; line_phase = 4'b0;
    pix_en = 1'b0; line_start = 1'b0; frame_start = 1'b0; nbr_sigs = '0;
    step();
    cfg_tick_sel = tsel; cfg_set_cnt = s; cfg_clr_cnt = c;
    cfg_start_mask = 8'b0100_0100; cfg_gsel = 4'd15; cfg_comb = 2'd2;
    cfg_pol = 1'b0; cfg_nbr_idx = 5'd7; cfg_en = 1'b1;
    step();
  endtask

  task automatic go_data();
    frame_phase = 4'b0100; line_phase = 4'b0100;
  endtask

  task automatic t_basic();
    rearm(2'd0, 16'd3, 16'd6);
    pix_en = 1'b1;
    go_data();
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R3/R5 window", sig_out, (k >= 3 && k < 6));
    end
  endtask

  task automatic t_mask();
    rearm(2'd0, 16'd0, 16'd9);
    frame_phase = 4'b0100; line_phase = 4'b0001; // line sync not enabled
    step(); step();
    chk("R1 unselected line phase", sig_out, 1'b0);
    line_phase = 4'b0100;
    step();
    chk("R1 selected phases start", sig_out, 1'b1);
  endtask

  task automatic t_global();
    rearm(2'd0, 16'd0, 16'd9);
    cfg_gsel = 4'd2; cfg_start_cnt = 12'd5;
    gcnt_bus = '0;
    gcnt_bus[11:0]  = 12'd5;
    gcnt_bus[35:24] = 12'd4;
    go_data();
    step(); step();
    chk("R2 other counter matches only", sig_out, 1'b0);
    gcnt_bus[35:24] = 12'd5;
    step();
    chk("R2 selected counter matches", sig_out, 1'b1);
    gcnt_bus = '0;
  endtask

  task automatic t_tick(input logic [1:0] tsel);
    rearm(tsel, 16'd2, 16'd100);
    pix_en = (tsel != 2'd0);
    go_data();
    step();
    step(); step(); step();
    chk("R4 no tick pulses yet", sig_out, 1'b0);
    for (int p = 1; p <= 2; p++) begin
      case (tsel)
        2'd1: line_start = 1'b1;
        2'd2: frame_start = 1'b1;
        default: nbr_sigs[7] = 1'b1;
      endcase
      step();
      line_start = 1'b0; frame_start = 1'b0; nbr_sigs = '0;
      #1;
      chk((tsel == 2'd3) ? "R4/R10 neighbour tick" : "R4 pulse tick", sig_out, (p == 2));
    end
  endtask

  task automatic t_comb();
    rearm(2'd0, 16'd0, 16'd9);
    go_data();
    step();
    cfg_comb = 2'd0; nbr_sigs[7] = 1'b0; #1;
    chk("R7 pass low", sig_out, 1'b0);
    nbr_sigs[7] = 1'b1; #1;
    chk("R7 pass high", sig_out, 1'b1);
    nbr_sigs = 32'h0000_0040; #1; // bit 6 only, index is 7
    chk("R10 unselected bit ignored", sig_out, 1'b0);
    cfg_comb = 2'd1; nbr_sigs[7] = 1'b1; #1;
    chk("R7 and high", sig_out, 1'b1);
    nbr_sigs = '0; #1;
    chk("R7 and low", sig_out, 1'b0);
    cfg_pol = 1'b1; cfg_comb = 2'd2; #1;
    chk("R8 inverted", sig_out, 1'b0);
    cfg_pol = 1'b0; #1;
    chk("R8 not inverted", sig_out, 1'b1);
    // start strobe
    rearm(2'd0, 16'd0, 16'd9);
    cfg_comb = 2'd3; nbr_sigs[7] = 1'b1;
    go_data();
    step();
    chk("R7 strobe present", sig_out, 1'b1);
    step();
    chk("R7 strobe one cycle", sig_out, 1'b0);
  endtask

  task automatic t_equal();
    rearm(2'd0, 16'd2, 16'd2);
    pix_en = 1'b1;
    go_data();
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 set wins on tie", sig_out, (k >= 2));
    end
  endtask

  task automatic t_sat();
    rearm(2'd0, 16'hFFFF, 16'd0);
    pix_en = 1'b1;
    go_data();
    step();
    chk("R3 start at zero", sig_out, 1'b0);
    for (int k = 0; k < 65535; k++) step();
    chk("R6 reaches top", sig_out, 1'b1);
    for (int k = 0; k < 5; k++) step();
    chk("R6 no wrap", sig_out, 1'b1);
    frame_phase = 4'b0; line_phase = 4'b0;
    step();
    go_data();
    step();
    chk("R6 restart clears", sig_out, 1'b0);
  endtask

  task automatic t_disable();
    rearm(2'd0, 16'd0, 16'd9);
    go_data();
    step();
    cfg_en = 1'b0; cfg_pol = 1'b1; cfg_comb = 2'd0; nbr_sigs[7] = 1'b1;
    step();
    chk("R9 idle level pol=1", sig_out, 1'b1);
    cfg_pol = 1'b0; #1;
    chk("R9 idle level pol=0", sig_out, 1'b0);
    frame_phase = 4'b0; line_phase = 4'b0; nbr_sigs = '0; cfg_comb = 2'd2;
    cfg_en = 1'b1; #1;
    chk("R9 raw cleared", sig_out, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pix_en = 0; line_start = 0; frame_start = 0;
    frame_phase = '0; line_phase = '0; gcnt_bus = '0; nbr_sigs = '0;
    cfg_en = 0; cfg_pol = 0; cfg_tick_sel = 0; cfg_gsel = 4'd15;
    cfg_start_cnt = '0; cfg_start_mask = '0; cfg_set_cnt = '0;
    cfg_clr_cnt = '0; cfg_comb = 0; cfg_nbr_idx = 5'd7;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R9 reset state", sig_out, 1'b0);
    t_basic();
    t_mask();
    t_global();
    t_tick(2'd1);
    t_tick(2'd2);
    t_tick(2'd3);
    t_comb();
    t_equal();
    t_sat();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule